// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block owns a small on-chip table of transmit descriptors and walks it as a ring. A host fills the table through a plain 32-bit register port that is addressed by word. Each descriptor is two words. The first is a status/control word that carries the frame length, the option flags and a ready handshake bit. The second is the buffer pointer.

The walker stays on its current descriptor until the host marks it ready. It then presents a fetch request to a downstream DMA. The request carries the buffer pointer, the frame length and the CRC and pad options, and it is held until the DMA answers with a completion strobe and an error flag. On completion the walker writes the status word back with the ready bit cleared and the outcome recorded. It can pulse an interrupt. It then moves to the next descriptor, or back to entry 0 when the descriptor asks for a wrap or when the table ends.

Top module: `txd_ring_walker`

## Requirements
- R1: Descriptor i occupies word address 2*i (status) and 2*i+1 (buffer pointer). A host read on `host_rdata` returns the stored word with no delay, and every word reads 0 after reset.
- R2: The ready flag is status bit 15. The walker polls only its current index and issues no fetch while that descriptor is not ready, even when later descriptors are ready.
- R3: A fetch request carries the pointer word, the length from status bits 31:16, the CRC option from bit 12 and the pad option from bit 11. These values stay stable and `fetch_req` stays high until `done_valid`. `fetch_req` is low in the cycle after `done_valid`.
- R4: On completion the status word is rewritten with bit 15 cleared and bit 0 set equal to `done_err`. All other bits are kept.
- R5: When the completed descriptor has the wrap flag set (status bit 13), the next index is 0. Otherwise the index advances by one.
- R6: After the last entry (index NUM_DESC-1) the index returns to 0, even when the wrap flag is clear.
- R7: A ready descriptor with length 0 raises no fetch. It is closed at once with bit 15 cleared and bit 0 set, and the walker then moves on as in R5 and R6.
- R8: `irq` is high for exactly one cycle, the cycle after a completion or a zero-length close, and only when status bit 14 of that descriptor is set.
- R9: A host write to a status word in the same cycle as the walker's write-back to that word is dropped, so the write-back value remains.
- R10: After reset `fetch_req` and `irq` are low and the walker polls index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | $clog2(NUM_DESC)+1 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at `host_addr` |
| fetch_req | output | 1 | Fetch request to the DMA |
| fetch_ptr | output | 32 | Buffer pointer of the request |
| fetch_len | output | 16 | Frame length in bytes |
| fetch_crc | output | 1 | Append CRC option |
| fetch_pad | output | 1 | Pad short frame option |
| done_valid | input | 1 | DMA completion strobe |
| done_err | input | 1 | Completion with error |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with the default eight-entry table, so the vector walk is short. Twelve descriptors exercise an early wrap through the flag and the forced return after the last entry, and they also include zero-length closes and both completion outcomes. Directed tests then cover several cases: a later ready descriptor while the current one is not ready, a host write colliding with a write-back, and the reset state.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned LEN_LSB = 16;
   localparam int unsigned LEN_W   = 16;
   localparam int unsigned B_RDY   = 15;
   localparam int unsigned B_IRQ   = 14;
   localparam int unsigned B_WRAP  = 13;
   localparam int unsigned B_CRC   = 12;
   localparam int unsigned B_PAD   = 11;
   localparam int unsigned B_ERR   = 0;

   typedef enum logic [0:0] {ST_POLL = 1'b0, ST_BUSY = 1'b1} walk_st_t;
endpackage

// File: rtl/txd_desc_mem.sv
module txd_desc_mem
   import txd_pkg::*;
#(
   parameter int unsigned NUM_DESC = 8,
   localparam int unsigned IW = $clog2(NUM_DESC),
   localparam int unsigned AW = IW + 1,
   localparam int unsigned NWORDS = 2 * NUM_DESC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              hw_we,
   input  logic [IW-1:0]     hw_idx,
   input  logic [WORD_W-1:0] hw_wdata,
   input  logic [IW-1:0]     rd_idx,
   output logic [WORD_W-1:0] stat_rdata,
   output logic [WORD_W-1:0] ptr_rdata
);
   logic [WORD_W-1:0] words [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] q;
      logic hw_hit, host_hit;
      if ((w % 2) == 0) begin : g_stat
         assign hw_hit = hw_we && (hw_idx == IW'(w / 2));
      end else begin : g_ptr
         assign hw_hit = 1'b0;
      end
      assign host_hit = host_we && (host_addr == AW'(w));
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= '0;
         else if (hw_hit)   q <= hw_wdata;
         else if (host_hit) q <= host_wdata;
      end
      assign words[w] = q;
   end

   assign host_rdata = words[host_addr];
   assign stat_rdata = words[{rd_idx, 1'b0}];
   assign ptr_rdata  = words[{rd_idx, 1'b1}];
endmodule

// File: rtl/txd_walk_fsm.sv
module txd_walk_fsm
   import txd_pkg::*;
#(
   parameter int unsigned NUM_DESC = 8,
   localparam int unsigned IW = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] stat,
   input  logic [WORD_W-1:0] ptr,
   input  logic              done_valid,
   input  logic              done_err,
   output logic [IW-1:0]     cur_idx,
   output logic              hw_we,
   output logic [WORD_W-1:0] hw_wdata,
   output logic              fetch_req,
   output logic [WORD_W-1:0] fetch_ptr,
   output logic [LEN_W-1:0]  fetch_len,
   output logic              fetch_crc,
   output logic              fetch_pad,
   output logic              irq
);
   walk_st_t          st;
   logic [WORD_W-1:0] held;
   logic [WORD_W-1:0] src;
   logic [LEN_W-1:0]  cur_len;
   logic              close_zero, finish, launch, last_ent;
   logic [IW-1:0]     nxt_idx;

   always_comb begin
      src        = (st == ST_BUSY) ? held : stat;
      cur_len    = stat[LEN_LSB +: LEN_W];
      close_zero = (st == ST_POLL) && stat[B_RDY] && (cur_len == '0);
      launch     = (st == ST_POLL) && stat[B_RDY] && (cur_len != '0);
      finish     = (st == ST_BUSY) && done_valid;
      hw_we      = close_zero || finish;
      hw_wdata   = src;
      hw_wdata[B_RDY] = 1'b0;
      hw_wdata[B_ERR] = close_zero ? 1'b1 : done_err;
      last_ent   = (cur_idx == IW'(NUM_DESC - 1));
      nxt_idx    = (src[B_WRAP] || last_ent) ? '0 : cur_idx + 1'b1;
   end

   assign fetch_len = held[LEN_LSB +: LEN_W];
   assign fetch_crc = held[B_CRC];
   assign fetch_pad = held[B_PAD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_POLL;
         cur_idx   <= '0;
         held      <= '0;
         fetch_ptr <= '0;
         fetch_req <= 1'b0;
         irq       <= 1'b0;
      end else begin
         irq <= hw_we && src[B_IRQ];
         if (hw_we) cur_idx <= nxt_idx;
         if (launch) begin
            held      <= stat;
            fetch_ptr <= ptr;
            fetch_req <= 1'b1;
            st        <= ST_BUSY;
         end
         if (finish) begin
            fetch_req <= 1'b0;
            st        <= ST_POLL;
         end
      end
   end
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
   import txd_pkg::*;
#(
   parameter int unsigned NUM_DESC = 8,
   localparam int unsigned IW = $clog2(NUM_DESC),
   localparam int unsigned AW = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              fetch_req,
   output logic [31:0]       fetch_ptr,
   output logic [15:0]       fetch_len,
   output logic              fetch_crc,
   output logic              fetch_pad,
   input  logic              done_valid,
   input  logic              done_err,
   output logic              irq
);
   if ((NUM_DESC < 2) || ((NUM_DESC & (NUM_DESC - 1)) != 0)) begin : g_bad_depth
      $error("NUM_DESC must be a power of two of at least 2");
   end

   logic [IW-1:0]     cur_idx;
   logic              hw_we;
   logic [WORD_W-1:0] hw_wdata, stat_w, ptr_w;

   txd_desc_mem #(.NUM_DESC(NUM_DESC)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .hw_we(hw_we), .hw_idx(cur_idx), .hw_wdata(hw_wdata),
      .rd_idx(cur_idx), .stat_rdata(stat_w), .ptr_rdata(ptr_w)
   );

   txd_walk_fsm #(.NUM_DESC(NUM_DESC)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .stat(stat_w), .ptr(ptr_w),
      .done_valid(done_valid), .done_err(done_err),
      .cur_idx(cur_idx), .hw_we(hw_we), .hw_wdata(hw_wdata),
      .fetch_req(fetch_req), .fetch_ptr(fetch_ptr), .fetch_len(fetch_len),
      .fetch_crc(fetch_crc), .fetch_pad(fetch_pad), .irq(irq)
   );
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
   parameter int unsigned NUM_DESC = 8,
   localparam int unsigned IW = $clog2(NUM_DESC)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_req,
   input logic [31:0]   fetch_ptr,
   input logic [15:0]   fetch_len,
   input logic          done_valid,
   input logic          irq,
   input logic [IW-1:0] cur_idx
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !done_valid) |=> (fetch_req && $stable(fetch_ptr) && $stable(fetch_len))); // R3
   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && done_valid) |=> !fetch_req); // R3
   AST_NO_ZERO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> (fetch_len != 16'd0)); // R7
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx != $past(cur_idx)) |-> ((cur_idx == '0) || (cur_idx == $past(cur_idx) + 1'b1))); // R2
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.NUM_DESC(NUM_DESC)) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ptr(fetch_ptr),
   .fetch_len(fetch_len), .done_valid(done_valid), .irq(irq), .cur_idx(cur_idx)
);

// File: tb/txd_ring_walker_bench.sv
`timescale 1ns/1ps
module txd_ring_walker_bench;
   localparam int unsigned ND = 8;
   localparam int unsigned AW = $clog2(ND) + 1;

   typedef struct packed {
      logic [31:0] ptr;
      logic [15:0] len;
      logic        irq;
      logic        wrap;
      logic        crc;
      logic        pad;
      logic        err;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{32'h1000_0000, 16'd64,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{32'h1000_0600, 16'd0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{32'h1000_0C00, 16'd1514, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
      '{32'h2000_0000, 16'd60,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{32'h2000_0040, 16'd42,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{32'h2000_0080, 16'd0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{32'h2000_00C0, 16'd100,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{32'h2000_0100, 16'd7,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      '{32'h2000_0140, 16'd200,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{32'h2000_0180, 16'd16,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      '{32'h2000_01C0, 16'd300,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{32'h3000_0000, 16'd52,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic fetch_req, fetch_crc, fetch_pad, irq;
   logic [31:0] fetch_ptr;
   logic [15:0] fetch_len;
   logic done_valid = 1'b0;
   logic done_err = 1'b0;
   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   txd_ring_walker #(.NUM_DESC(ND)) u_txd_ring_walker (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .fetch_req(fetch_req),
      .fetch_ptr(fetch_ptr), .fetch_len(fetch_len), .fetch_crc(fetch_crc),
      .fetch_pad(fetch_pad), .done_valid(done_valid), .done_err(done_err), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input int addr, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(addr); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hread(input int addr, output logic [31:0] d);
      @(negedge clk);
      host_addr = AW'(addr);
      #1 d = host_rdata;
   endtask

   task automatic wait_fetch(input string req);
      int n = 0;
      while (!fetch_req && n < 100) begin @(negedge clk); n++; end
      chk(req, 32'(fetch_req), 32'd1);
   endtask

   task automatic complete(input logic e, input bit coll, input int caddr);
      @(negedge clk);
      done_valid = 1'b1; done_err = e;
      if (coll) begin host_we = 1'b1; host_addr = AW'(caddr); host_wdata = 32'hFFFF_8000; end
      @(negedge clk);
      done_valid = 1'b0; done_err = 1'b0; host_we = 1'b0;
   endtask

   function automatic logic [31:0] mk_stat(input vec_t v);
      return {v.len, 1'b1, v.irq, v.wrap, v.crc, v.pad, 11'd0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd, st, exp_st;
      int idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 / R1 reset state
      chk("R10 fetch_req after reset", 32'(fetch_req), 32'd0);
      chk("R10 irq after reset", 32'(irq), 32'd0);
      hread(0, rd); chk("R1 status word 0 reset", rd, 32'd0);
      hread(1, rd); chk("R1 pointer word 1 reset", rd, 32'd0);

      for (int k = 0; k < 12; k++) begin
         st = mk_stat(VEC[k]);
         hwrite(2*idx + 1, VEC[k].ptr);
         hread(2*idx + 1, rd); chk("R1 pointer readback", rd, VEC[k].ptr);
         hwrite(2*idx, st);
         if (VEC[k].len == 16'd0) begin
            @(negedge clk);
            chk("R8 irq on zero-length close", 32'(irq), 32'(VEC[k].irq));
            chk("R7 no fetch for zero length", 32'(fetch_req), 32'd0);
            @(negedge clk);
            chk("R8 irq single cycle", 32'(irq), 32'd0);
            exp_st = (st & ~32'h8000) | 32'h1;
            hread(2*idx, rd); chk("R7 zero-length status", rd, exp_st);
         end else begin
            wait_fetch("R2 fetch raised on ready");
            chk("R3 fetch pointer", fetch_ptr, VEC[k].ptr);
            chk("R3 fetch length", 32'(fetch_len), 32'(VEC[k].len));
            chk("R3 crc option", 32'(fetch_crc), 32'(VEC[k].crc));
            chk("R3 pad option", 32'(fetch_pad), 32'(VEC[k].pad));
            complete(VEC[k].err, 1'b0, 0);
            chk("R8 irq after completion", 32'(irq), 32'(VEC[k].irq));
            chk("R3 request drops", 32'(fetch_req), 32'd0);
            @(negedge clk);
            chk("R8 irq single cycle", 32'(irq), 32'd0);
            exp_st = (st & ~32'h8000) | 32'(VEC[k].err);
            hread(2*idx, rd); chk("R4 status write-back", rd, exp_st);
         end
         // R5 wrap flag, R6 forced wrap at last entry
         idx = (VEC[k].wrap || idx == ND - 1) ? 0 : idx + 1;
      end

      // R2: later descriptor ready, current not ready -> no fetch
      hwrite(3, 32'hA000_0000);
      hwrite(2, {16'd10, 16'h8000});
      repeat (20) @(negedge clk);
      chk("R2 no skip ahead", 32'(fetch_req), 32'd0);
      hwrite(1, 32'hB000_0000);
      hwrite(0, {16'd20, 16'h8000});
      wait_fetch("R2 current index fetched");
      chk("R2 current served first", fetch_ptr, 32'hB000_0000);
      complete(1'b0, 1'b0, 0);
      wait_fetch("R2 next index fetched");
      chk("R2 next served second", fetch_ptr, 32'hA000_0000);
      complete(1'b0, 1'b0, 0);

      // R9: host write collides with write-back on status of index 2
      hwrite(5, 32'hC000_0000);
      hwrite(4, {16'd30, 16'h9000});
      wait_fetch("R9 fetch before collision");
      complete(1'b0, 1'b1, 4);
      hread(4, rd); chk("R9 write-back wins", rd, {16'd30, 16'h1000});
      repeat (10) @(negedge clk);
      chk("R9 no refetch after collision", 32'(fetch_req), 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule